// File: doc/BRIEF.md
# Reciprocal Tone Frequency Counter

This block measures the frequency of a clean, already-filtered tone. The tone arrives as a one-bit level. Each measurement starts on a qualifying tone edge and runs for a fixed gate of 511 measuring ticks. During the gate the block counts the qualifying edges. It also records the tick index at which the last one arrived. When the gate closes it reports two values. N is the edge count. R is the number of ticks left between the last counted edge and the end of the gate. Software recovers the frequency as k·N/(511−R), where k is 28000, 14000 or 56000 for the high, mid and extended band respectively (nominal clock).

The measuring tick comes from the `tickEn` strobe, nominally one pulse per 72 system clocks (56 kHz at 4.032 MHz). In mid band the block uses only every second strobe, so the gate lasts twice as long. High and mid band count both tone edges, which is twice the tone frequency. Extended band counts rising edges only. The block re-arms on its own after each gate. An abort input throws away the measurement in progress. A progress output tells a no-tone timer that the gate is more than three quarters through.

Top module: `tone_freq_meter`

## Requirements
- R1: After reset `resultOut` is 0, and `doneOut` and `progressOut` are 0.
- R2: `bandSel` selects the band: 2'b00 high, 2'b01 mid, 2'b10 extended, 2'b11 behaves as high. The band is latched when a measurement starts. While idle, the first qualifying edge starts a measurement; that edge is not itself counted.
- R3: In high band each `tickEn` pulse is one measuring tick. Both tone edges qualify. With counted edges spaced P ticks apart, N = floor(510/P) and R = 511 − N·P.
- R4: In mid band only every second `tickEn` pulse after the start is a measuring tick. N and R follow the same formula in measuring ticks.
- R5: In extended band only rising tone edges qualify. N and R follow the same formula.
- R6: `resultOut[13:8]` holds N and `resultOut[5:0]` holds R. Bits 15:14 and 7:6 are always 0.
- R7: A successful measurement raises `doneOut` for exactly one clock, in the same cycle that `resultOut` takes the new value. At all other times `resultOut` holds its value.
- R8: A measurement with N = 0, N > 63 or R > 63 is discarded: no `doneOut` pulse and no change to `resultOut`.
- R9: `abortIn` ends the measurement in progress without an update. The block then waits for the next qualifying edge and starts afresh.
- R10: `progressOut` is high while the measuring tick count is between 384 and 510, that is, during the last 127 measuring ticks before `doneOut`. It is low when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Measuring-tick strobe derived from the system clock |
| toneIn | input | 1 | Digitised tone level |
| bandSel | input | 2 | Band select (00 high, 01 mid, 10 extended, 11 as high) |
| abortIn | input | 1 | Discard the measurement in progress |
| resultOut | output | 16 | {2'b0, N, 2'b0, R} |
| doneOut | output | 1 | One-cycle pulse when a result is posted |
| progressOut | output | 1 | Gate more than three quarters elapsed |

## Verification
The hardest cases to reach are the boundaries where a result is only just accepted or only just rejected, such as R = 63 against R = 64 and N = 63 against N = 72. Each of these depends on where the final tone edge falls relative to the closing tick of the gate. The bench places every tone edge exactly two clocks after a `tickEn` pulse and chooses integer edge spacings that land on these values. Because no edge can then coincide with a tick, each outcome is determined exactly. An abort is issued midway through a running gate while the tone continues, which forces the restart onto a later edge of the same stream.

// File: rtl/tone_meas_pkg.sv
package tone_meas_pkg;
  typedef enum logic [1:0] {
    BAND_HIGH = 2'b00,
    BAND_MID  = 2'b01,
    BAND_EXT  = 2'b10,
    BAND_RSVD = 2'b11
  } band_e;

  typedef struct packed {
    logic clearAcc;
    logic edgeHit;
    logic finish;
  } strobe_t;
endpackage

// File: rtl/tone_meas_ctrl.sv
module tone_meas_ctrl
  import tone_meas_pkg::*;
#(
  parameter int GATE_TICKS = 511,
  localparam int TW = $clog2(GATE_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          toneIn,
  input  logic [1:0]    bandSel,
  input  logic          abortIn,
  output strobe_t       strobes,
  output logic [TW-1:0] tickIdx,
  output logic          progressOut
);
  localparam int PROG_LIMIT = (GATE_TICKS * 3) / 4;

  logic          toneQ, measuring, phaseQ;
  band_e         bandQ;
  logic [TW-1:0] tickCnt;
  logic          riseNow, anyEdge, startNow, measTick, gateEnd, edgeLatched;

  function automatic logic qualEdge(band_e b, logic r, logic a);
    return (b == BAND_EXT) ? r : a;
  endfunction

  assign riseNow     = toneIn & ~toneQ;
  assign anyEdge     = toneIn ^ toneQ;
  assign startNow    = !measuring && !abortIn && qualEdge(band_e'(bandSel), riseNow, anyEdge);
  assign measTick    = measuring && tickEn && (bandQ != BAND_MID || phaseQ);
  assign gateEnd     = measTick && (tickCnt == TW'(GATE_TICKS - 1));
  assign edgeLatched = qualEdge(bandQ, riseNow, anyEdge);

  assign strobes.clearAcc = startNow;
  assign strobes.edgeHit  = measuring && !abortIn && edgeLatched && !gateEnd;
  assign strobes.finish   = measuring && !abortIn && gateEnd;
  assign tickIdx          = tickCnt;
  assign progressOut      = measuring && (tickCnt > TW'(PROG_LIMIT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toneQ     <= 1'b0;
      measuring <= 1'b0;
      phaseQ    <= 1'b0;
      bandQ     <= BAND_HIGH;
      tickCnt   <= '0;
    end else begin
      toneQ <= toneIn;
      if (abortIn) begin
        measuring <= 1'b0;
      end else if (startNow) begin
        measuring <= 1'b1;
        bandQ     <= band_e'(bandSel);
        phaseQ    <= 1'b0;
        tickCnt   <= '0;
      end else if (measuring) begin
        if (tickEn && bandQ == BAND_MID) phaseQ <= ~phaseQ;
        if (measTick) begin
          tickCnt <= tickCnt + 1'b1;
          if (gateEnd) measuring <= 1'b0;
        end
      end
    end
  end

  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortIn |=> !progressOut);
  // R10
  tick_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    measuring |-> (tickCnt < TW'(GATE_TICKS)));
  // R10
  finish_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> !progressOut);
endmodule

// File: rtl/tone_meas_dp.sv
module tone_meas_dp
  import tone_meas_pkg::*;
#(
  parameter int GATE_TICKS = 511,
  parameter int NW = 6,
  parameter int RW = 6,
  localparam int TW = $clog2(GATE_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobes,
  input  logic [TW-1:0] tickIdx,
  output logic [NW-1:0] nOut,
  output logic [RW-1:0] rOut,
  output logic          doneOut
);
  localparam int NMAX = (1 << NW) - 1;
  localparam int RMAX = (1 << RW) - 1;

  logic [TW-1:0] edgeCnt, lastIdx, remain;
  logic          accept;

  assign remain = TW'(GATE_TICKS) - lastIdx;
  assign accept = (edgeCnt != '0) && (edgeCnt <= TW'(NMAX)) && (remain <= TW'(RMAX));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeCnt <= '0;
      lastIdx <= '0;
      nOut    <= '0;
      rOut    <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= 1'b0;
      if (strobes.clearAcc) begin
        edgeCnt <= '0;
        lastIdx <= '0;
      end else if (strobes.edgeHit) begin
        if (edgeCnt != '1) edgeCnt <= edgeCnt + 1'b1;
        lastIdx <= tickIdx;
      end
      if (strobes.finish && accept) begin
        nOut    <= NW'(edgeCnt);
        rOut    <= RW'(remain);
        doneOut <= 1'b1;
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !doneOut |-> $stable({nOut, rOut}));
  // R8
  nonzero_n_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (nOut != '0));
endmodule

// File: rtl/tone_freq_meter.sv
module tone_freq_meter
  import tone_meas_pkg::*;
#(
  parameter int GATE_TICKS = 511,
  parameter int NW = 6,
  parameter int RW = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        toneIn,
  input  logic [1:0]  bandSel,
  input  logic        abortIn,
  output logic [15:0] resultOut,
  output logic        doneOut,
  output logic        progressOut
);
  localparam int TW = $clog2(GATE_TICKS + 1);
  localparam int BYTE = 8;

  strobe_t       strobes;
  logic [TW-1:0] tickIdx;
  logic [NW-1:0] nVal;
  logic [RW-1:0] rVal;

  tone_meas_ctrl #(.GATE_TICKS(GATE_TICKS)) ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .toneIn(toneIn),
    .bandSel(bandSel), .abortIn(abortIn), .strobes(strobes),
    .tickIdx(tickIdx), .progressOut(progressOut)
  );

  tone_meas_dp #(.GATE_TICKS(GATE_TICKS), .NW(NW), .RW(RW)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tickIdx(tickIdx),
    .nOut(nVal), .rOut(rVal), .doneOut(doneOut)
  );

  // R6: two bytes, N byte in the upper half, padding bits zero
  assign resultOut = {{(BYTE-NW){1'b0}}, nVal, {(BYTE-RW){1'b0}}, rVal};
endmodule

// File: tb/tone_freq_meter_test.sv
module tone_freq_meter_test;
  logic        clk = 1'b0;
  logic        rstN, tickEn, toneIn, abortIn;
  logic [1:0]  bandSel;
  logic [15:0] resultOut;
  logic        doneOut, progressOut;

  int checks = 0, fails = 0;
  int cyc = 0, toneBase = 0, halfLen = 1;
  logic toneOn = 1'b0;

  always #10 clk = ~clk;

  tone_freq_meter uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .toneIn(toneIn),
    .bandSel(bandSel), .abortIn(abortIn), .resultOut(resultOut),
    .doneOut(doneOut), .progressOut(progressOut)
  );

  // stimulus generator: tick every 4 clocks, tone edges 2 clocks after a tick
  always @(negedge clk) begin
    cyc    = cyc + 1;
    tickEn = (cyc % 4 == 0);
    toneIn = toneOn && (cyc >= toneBase) && (((cyc - toneBase) / halfLen) % 2 == 0);
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic quiesce();
    @(negedge clk);
    toneOn  = 1'b0;
    abortIn = 1'b1;
    @(negedge clk);
    abortIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic startTone(input logic [1:0] band, input int p);
    int d, tb;
    d  = (band == 2'b01) ? 2 * p : p;
    tb = cyc + 8;
    tb = tb + ((2 - (tb % 4)) + 4) % 4;
    halfLen  = (band == 2'b10) ? 2 * d : 4 * d;
    toneBase = tb;
    toneOn   = 1'b1;
  endtask

  // wait for done; returns progress-high count before it
  task automatic waitDone(output bit seen, output int progCnt);
    seen = 0;
    progCnt = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (doneOut) begin
        seen = 1;
        break;
      end
      if (progressOut) progCnt++;
    end
  endtask

  task automatic measure(input logic [1:0] band, input int p, input string req);
    int n, r, progCnt, tickPer;
    bit valid, seen;
    logic [15:0] prev;
    quiesce();
    bandSel = band;
    prev    = resultOut;
    n       = 510 / p;
    r       = 511 - n * p;
    valid   = (n >= 1) && (n <= 63) && (r <= 63);
    tickPer = (band == 2'b01) ? 8 : 4;
    startTone(band, p);
    waitDone(seen, progCnt);
    if (valid) begin
      chk(seen, req, "done seen", int'(seen), 1);
      chk(resultOut == {2'b00, n[5:0], 2'b00, r[5:0]}, req, "result (R6 layout)", int'(resultOut),
          int'({2'b00, n[5:0], 2'b00, r[5:0]}));
      chk(progCnt == 127 * tickPer, "R10", "progress clocks", progCnt, 127 * tickPer);
      @(negedge clk);
      chk(!doneOut, "R7", "done width", int'(doneOut), 0);
    end else begin
      chk(!seen, "R8", "no done on bad measurement", int'(seen), 0);
      chk(resultOut == prev, "R8", "result kept", int'(resultOut), int'(prev));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int progCnt;
    bit seen;
    logic [15:0] prev;
    rstN = 1'b0; abortIn = 1'b0; bandSel = 2'b00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(resultOut == 16'h0, "R1", "reset result", int'(resultOut), 0);
    chk(!doneOut, "R1", "reset done", int'(doneOut), 0);
    chk(!progressOut, "R1", "reset progress", int'(progressOut), 0);

    // R3: high band sweep with boundary cases
    for (int p = 8; p <= 64; p += 8) measure(2'b00, p, "R3");
    measure(2'b00, 7,   "R8");   // N = 72 too large
    measure(2'b00, 149, "R8");   // R = 64 too large
    measure(2'b00, 120, "R3");   // N = 4, R = 31
    measure(2'b00, 600, "R8");   // no counted edge
    // R4: mid band
    measure(2'b01, 8,  "R4");
    measure(2'b01, 37, "R4");
    measure(2'b01, 64, "R4");
    measure(2'b01, 73, "R8");
    // R5: extended band
    measure(2'b10, 9,  "R5");
    measure(2'b10, 30, "R5");
    measure(2'b10, 64, "R5");
    // R2: reserved code acts as high band
    measure(2'b11, 25, "R2");

    // R9: abort with tone stopped -> no result
    quiesce();
    bandSel = 2'b00;
    prev = resultOut;
    startTone(2'b00, 20);
    repeat (800) @(negedge clk);
    toneOn = 1'b0;
    abortIn = 1'b1;
    @(negedge clk);
    abortIn = 1'b0;
    @(negedge clk);
    chk(!progressOut, "R9", "progress after abort", int'(progressOut), 0);
    waitDone(seen, progCnt);
    chk(!seen, "R9", "no done after abort", int'(seen), 0);
    chk(resultOut == prev, "R9", "result kept after abort", int'(resultOut), int'(prev));

    // R9: abort mid-gate while tone continues -> clean restart
    quiesce();
    startTone(2'b00, 21);
    repeat (1000) @(negedge clk);
    abortIn = 1'b1;
    @(negedge clk);
    abortIn = 1'b0;
    waitDone(seen, progCnt);
    chk(seen, "R9", "done after restart", int'(seen), 1);
    chk(resultOut == {2'b00, 6'd24, 2'b00, 6'd7}, "R9", "restart result", int'(resultOut),
        int'({2'b00, 6'd24, 2'b00, 6'd7}));
    chk(progCnt == 508, "R10", "progress clocks after restart", progCnt, 508);

    quiesce();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule